// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction

This block rebuilds one 4x4 block of 8-bit pixels from a 4x4 block of signed 16-bit transform coefficients and a matching 4x4 block of unsigned 8-bit prediction samples. It applies a separable integer inverse transform in two passes. The first pass runs down the columns and the second runs along the rows of the first pass result. The residual from the second pass is then added to the prediction and clipped to the pixel range.

Every 1-D pass uses the same 4-point butterfly, built from the constants 64, 83 and 36. The two passes differ only in their rounding shift. Each pass saturates its results to signed 16 bits. A whole block arrives in parallel on one valid/ready transfer. The reconstructed block appears two clock cycles later with a one-cycle valid pulse. One block can be accepted on every cycle.

Top module: `itr_recon4x4`

## Requirements
- R1: For a line of four inputs x0..x3, a pass forms a = 64*(x0+x2), b = 64*(x0-x2), p = 83*x1 + 36*x3 and q = 36*x1 - 83*x3. It produces, as outputs 0 to 3, a+p, b+q, b-q and a-p.
- R2: The first pass adds 64 to each butterfly output, shifts right arithmetically by 7 and saturates to -32768..32767.
- R3: The second pass adds 2048 to each butterfly output, shifts right arithmetically by 12 and saturates to -32768..32767.
- R4: Coefficient row r, column c sits at in_coef bits [(4r+c)*16 +: 16]. The first pass on column c takes rows 0..3 as x0..x3, and its output k becomes row k of an intermediate matrix. The second pass on each intermediate row yields the residual row in column order. Prediction and output samples use the same row-major layout, at 8 bits per sample.
- R5: Each output sample is the signed residual plus the zero-extended prediction sample, clipped to 0..255.
- R6: Products and sums inside a pass keep 32-bit signed precision, so coefficients of -32768 or 32767 give exact results before the shift.
- R7: in_ready is high whenever rst is low. A block accepted on a clock edge (in_valid and in_ready both high) raises out_valid for exactly one cycle, two edges later. Blocks accepted on consecutive edges appear on consecutive cycles.
- R8: While out_valid is low, out_pix holds the last result, whatever in_coef and in_pred do.
- R9: While rst is high on a clock edge, out_valid and out_pix are cleared to zero and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A coefficient and prediction block is present |
| in_ready | output | 1 | The block can take a transfer |
| in_coef | input | 256 | 16 signed 16-bit coefficients, row-major |
| in_pred | input | 128 | 16 unsigned 8-bit prediction samples, row-major |
| out_valid | output | 1 | One-cycle pulse marking a new reconstructed block |
| out_pix | output | 128 | 16 reconstructed 8-bit samples, row-major, held between results |

## Verification
The pipeline has one register stage between the passes and one at the output, so a corrupted intermediate row or a misplaced valid bit shows up on out_pix or out_valid two cycles after the block that caused it. An orientation error, such as a swapped column and row pass or a missing transpose, leaves symmetric blocks intact. It is exposed by single off-diagonal coefficients. Rounding and saturation faults show up as off-by-one residuals on small coefficients and on full-scale coefficients, which the unsigned clip at the output does not hide when the prediction sits mid-range.

// File: rtl/itr_pkg.sv
package itr_pkg;
  localparam int ACC_W    = 32;
  localparam int K_EVEN   = 64;
  localparam int K_ODD_HI = 83;
  localparam int K_ODD_LO = 36;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [3:0][ACC_W-1:0] acc4_t;

  // add half an LSB of the result, then arithmetic shift
  function automatic acc_t round_shift(input acc_t v, input int sh);
    acc_t bias;
    bias = acc_t'(1) <<< (sh - 1);
    return (v + bias) >>> sh;
  endfunction

  // even/odd 4-point butterfly, outputs in natural order
  function automatic acc4_t butterfly(input acc_t x0, input acc_t x1,
                                      input acc_t x2, input acc_t x3);
    acc_t ev_sum, ev_dif, od_a, od_b;
    acc4_t y;
    ev_sum = K_EVEN * (x0 + x2);
    ev_dif = K_EVEN * (x0 - x2);
    od_a   = K_ODD_HI * x1 + K_ODD_LO * x3;
    od_b   = K_ODD_LO * x1 - K_ODD_HI * x3;
    y[0] = ev_sum + od_a;
    y[1] = ev_dif + od_b;
    y[2] = ev_dif - od_b;
    y[3] = ev_sum - od_a;
    return y;
  endfunction
endpackage

// File: rtl/itr_line.sv
module itr_line
  import itr_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int SHIFT = 7
) (
  input  logic [3:0][IN_W-1:0]  x,
  output logic [3:0][OUT_W-1:0] y
);
  localparam acc_t MAXV = acc_t'((longint'(1) <<< (OUT_W - 1)) - 1);
  localparam acc_t MINV = -MAXV - acc_t'(1);

  acc4_t raw;

  always_comb begin
    raw = butterfly(acc_t'($signed(x[0])), acc_t'($signed(x[1])),
                    acc_t'($signed(x[2])), acc_t'($signed(x[3])));
  end

  for (genvar k = 0; k < 4; k++) begin : g_out
    acc_t shv;
    always_comb begin
      shv = round_shift($signed(raw[k]), SHIFT);
      if (shv > MAXV)      y[k] = MAXV[OUT_W-1:0];
      else if (shv < MINV) y[k] = MINV[OUT_W-1:0];
      else                 y[k] = shv[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/itr_recon.sv
module itr_recon #(
  parameter int RES_W = 16,
  parameter int PIX_W = 8
) (
  input  logic [RES_W-1:0] res,
  input  logic [PIX_W-1:0] pred,
  output logic [PIX_W-1:0] pix
);
  localparam int SUM_W = RES_W + 2;
  localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << PIX_W) - 1);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'($signed(res)) + SUM_W'({1'b0, pred});
    if (sum < 0)         pix = '0;
    else if (sum > PMAX) pix = '1;
    else                 pix = sum[PIX_W-1:0];
  end
endmodule

// File: rtl/itr_recon4x4.sv
module itr_recon4x4
  import itr_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8,
  parameter int SHIFT1 = 7,
  parameter int SHIFT2 = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [16*COEF_W-1:0]     in_coef,
  input  logic [16*PIX_W-1:0]      in_pred,
  output logic                     out_valid,
  output logic [16*PIX_W-1:0]      out_pix
);
  localparam int N     = 4;
  localparam int MID_W = COEF_W;

  logic accept;
  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;

  // column pass
  logic [N-1:0][N-1:0][COEF_W-1:0] col_in;
  logic [N-1:0][N-1:0][MID_W-1:0]  col_out;

  for (genvar c = 0; c < N; c++) begin : g_col
    for (genvar r = 0; r < N; r++) begin : g_tap
      assign col_in[c][r] = in_coef[(r*N+c)*COEF_W +: COEF_W];
    end
    itr_line #(.IN_W(COEF_W), .OUT_W(MID_W), .SHIFT(SHIFT1)) u_col (
      .x(col_in[c]),
      .y(col_out[c])
    );
  end

  // intermediate register, stored row-major (transpose of column results)
  logic [N-1:0][N-1:0][MID_W-1:0] s1_mid;
  logic [16*PIX_W-1:0]            s1_pred;
  logic                           s1_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_mid   <= '0;
      s1_pred  <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++)
            s1_mid[r][c] <= col_out[c][r];
        s1_pred <= in_pred;
      end
    end
  end

  // row pass and reconstruction
  logic [N-1:0][N-1:0][MID_W-1:0] row_out;
  logic [16*PIX_W-1:0]            pix_next;

  for (genvar r = 0; r < N; r++) begin : g_row
    itr_line #(.IN_W(MID_W), .OUT_W(MID_W), .SHIFT(SHIFT2)) u_row (
      .x(s1_mid[r]),
      .y(row_out[r])
    );
    for (genvar c = 0; c < N; c++) begin : g_pix
      itr_recon #(.RES_W(MID_W), .PIX_W(PIX_W)) u_rc (
        .res (row_out[r][c]),
        .pred(s1_pred[(r*N+c)*PIX_W +: PIX_W]),
        .pix (pix_next[(r*N+c)*PIX_W +: PIX_W])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= pix_next;
    end
  end
endmodule

// File: rtl/itr_recon4x4_chk.sv
module itr_recon4x4_chk #(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [16*COEF_W-1:0] in_coef,
  input logic [16*PIX_W-1:0]  in_pred,
  input logic                 out_valid,
  input logic [16*PIX_W-1:0]  out_pix
);
  logic take;
  logic zero_take;
  assign take      = in_valid && in_ready;
  assign zero_take = take && (in_coef == '0);

  // R7
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(take, 2));

  // R7
  ready_out_of_reset_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_pix));

  // R9
  valid_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R5
  zero_residual_passes_pred_chk: assert property (@(posedge clk) disable iff (rst)
    $past(zero_take, 2) |-> out_pix == $past(in_pred, 2));
endmodule

bind itr_recon4x4 itr_recon4x4_chk #(.COEF_W(COEF_W), .PIX_W(PIX_W)) chk_i (.*);

// File: tb/itr_recon4x4_tb_top.sv
`timescale 1ns/1ps
module itr_recon4x4_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_coef = '0;
  logic [127:0] in_pred = '0;
  logic         out_valid;
  logic [127:0] out_pix;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  itr_recon4x4 dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_pred(in_pred), .out_valid(out_valid), .out_pix(out_pix)
  );

  // basis: output n of a line = sum over k of basis(k,n) * x[k]
  function automatic int basis(int k, int n);
    case (k)
      0: return 64;
      1: case (n) 0: return 83; 1: return 36; 2: return -36; default: return -83; endcase
      2: return (n == 0 || n == 3) ? 64 : -64;
      default: case (n) 0: return 36; 1: return -83; 2: return 83; default: return -36; endcase
    endcase
  endfunction

  function automatic int clamp(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic logic [127:0] model(logic [255:0] c, logic [127:0] p);
    int mid [4][4];
    logic [127:0] o;
    for (int col = 0; col < 4; col++)
      for (int n = 0; n < 4; n++) begin
        int acc = 0;
        for (int k = 0; k < 4; k++)
          acc += basis(k, n) * int'($signed(c[(k*4+col)*16 +: 16]));
        mid[n][col] = clamp((acc + 64) >>> 7, -32768, 32767);
      end
    for (int r = 0; r < 4; r++)
      for (int n = 0; n < 4; n++) begin
        int acc = 0;
        int res;
        for (int k = 0; k < 4; k++) acc += basis(k, n) * mid[r][k];
        res = clamp((acc + 2048) >>> 12, -32768, 32767);
        o[(r*4+n)*8 +: 8] = 8'(clamp(res + int'(p[(r*4+n)*8 +: 8]), 0, 255));
      end
    return o;
  endfunction

  function automatic logic [255:0] put(logic [255:0] v, int r, int c, int val);
    v[(r*4+c)*16 +: 16] = 16'(val);
    return v;
  endfunction

  task automatic next_rand(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  task automatic check_vec(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one block through the pipe; checks the pulse and data (R7)
  task automatic run_block(string req, logic [255:0] c, logic [127:0] p);
    logic [127:0] exp;
    exp = model(c, p);
    @(negedge clk);
    in_valid = 1'b1; in_coef = c; in_pred = p;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_bit({req, " R7 valid"}, out_valid, 1'b1);
    check_vec(req, out_pix, exp);
    @(negedge clk);
    check_bit({req, " R7 pulse"}, out_valid, 1'b0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_bit("R9 valid in reset", out_valid, 1'b0);
    check_bit("R9 ready in reset", in_ready, 1'b0);
    check_vec("R9 pix in reset", out_pix, '0);
    rst = 1'b0;
    #0;
    check_bit("R7 ready after reset", in_ready, 1'b1);
  endtask

  task automatic t_zero;
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'(i * 17);
    run_block("R5 zero block", '0, p);
  endtask

  task automatic t_dc;
    logic [127:0] p;
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'(240 + i);
    run_block("R5 dc clip high", put('0, 0, 0, 64), p);
    for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'(i);
    run_block("R5 dc clip low", put('0, 0, 0, -640), p);
    run_block("R2 R3 rounding small dc", put('0, 0, 0, 3), {16{8'd100}});
  endtask

  task automatic t_single;
    run_block("R4 coef r0c1", put('0, 0, 1, 900), {16{8'd128}});
    run_block("R4 coef r1c0", put('0, 1, 0, 900), {16{8'd128}});
    run_block("R1 coef r3c2", put('0, 3, 2, -1200), {16{8'd128}});
    run_block("R1 odd mix", put(put('0, 1, 1, 500), 3, 3, -300), {16{8'd90}});
  endtask

  task automatic t_extreme;
    logic [255:0] c;
    run_block("R6 all min", {16{16'h8000}}, {16{8'd128}});
    run_block("R6 all max", {16{16'h7fff}}, {16{8'd128}});
    c = '0;
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) c = put(c, r, k, ((r + k) % 2 == 0) ? 32767 : -32768);
    run_block("R2 checker sat", c, {16{8'd128}});
    c = '0;
    for (int r = 0; r < 4; r++)
      for (int k = 0; k < 4; k++) c = put(c, r, k, (r < 2) ? 32767 : -32768);
    run_block("R3 split sat", c, {16{8'd60}});
  endtask

  task automatic t_random;
    logic [255:0] c;
    logic [127:0] p;
    logic [31:0]  v;
    for (int i = 0; i < 24; i++) begin
      for (int k = 0; k < 16; k++) begin
        next_rand(v);
        c[k*16 +: 16] = (i % 3 == 0) ? v[15:0] : 16'($signed(v[10:0]));
        p[k*8 +: 8]   = v[23:16];
      end
      run_block("R1 R4 random", c, p);
    end
  endtask

  task automatic t_stream;
    logic [255:0] cs [6];
    logic [127:0] ps [6];
    logic [127:0] ex [6];
    logic [31:0]  v;
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 16; k++) begin
        next_rand(v);
        cs[b][k*16 +: 16] = 16'($signed(v[9:0]));
        ps[b][k*8 +: 8]   = v[31:24];
      end
      ex[b] = model(cs[b], ps[b]);
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check_bit("R7 stream valid", out_valid, 1'b1);
        check_vec("R7 stream data", out_pix, ex[i-2]);
      end
      if (i < 6) begin
        in_valid = 1'b1; in_coef = cs[i]; in_pred = ps[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check_bit("R7 stream end", out_valid, 1'b0);
  endtask

  task automatic t_hold;
    logic [127:0] held;
    logic [31:0]  v;
    run_block("R8 setup", put('0, 2, 1, 700), {16{8'd77}});
    held = out_pix;
    for (int i = 0; i < 5; i++) begin
      next_rand(v);
      in_coef = {8{v}};
      in_pred = {4{~v}};
      @(negedge clk);
      check_bit("R8 idle valid", out_valid, 1'b0);
      check_vec("R8 idle hold", out_pix, held);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_zero;
    t_dc;
    t_single;
    t_extreme;
    t_random;
    t_stream;
    t_hold;
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule